// File: doc/BRIEF.md
# Dual-Calendar Status Update Scheduler

This block produces the ordered stream of logical-port numbers that paces FIFO status reporting on a SPI-4 style status path. Two calendars of 256 eight-bit entries are kept side by side. On every cycle where the downstream status formatter asks for a slot, the block reads the next entry of the active calendar and emits it as a port number. A port that needs faster updates is simply written into more entries.

A host programs and inspects both calendars through a small write/read port, and sets the pass length, which is how many entries are walked before the index returns to entry 0. A calendar-selection word seen on the status path requests a change of calendar. The request is honoured only while switching is enabled, and always at the end of a pass, so a pass is never split between two calendars. With switching disabled, calendar 0 alone supplies the stream.

Top module: `status_cal_sched`

## Requirements
- R1: After reset, out_valid and cfg_rvalid are 0, calendar 0 is active, the index is 0, the pass length is 256 and every entry of both calendars holds 0x00.
- R2: With cfg_we high, cfg_wdata is stored in entry cfg_addr of calendar cfg_cal (0 or 1) at the clock edge. With cfg_rd high, cfg_rvalid is high in the next cycle and cfg_rdata holds that entry as it was before any write in the same cycle; cfg_rvalid is 0 otherwise.
- R3: A cycle with step_en high makes the next cycle show out_valid=1 and out_port equal to the entry at the current index of the active calendar; the index then advances by one. With step_en low, out_valid is 0 the next cycle and the index holds. A port written into several entries is emitted once per such entry.
- R4: out_first is 1 exactly on emissions taken from entry 0, and 0 whenever out_valid is 0.
- R5: A len_we write of a value from 1 to 256 sets the pass length from the next cycle on; values 0 and above 256 leave it unchanged. The step taking entry length-1 wraps the index to 0.
- R6: If the length is lowered to or below the current index, the next step emits the current entry and wraps to 0.
- R7: With sw_en low, sel_valid is ignored, and any step that wraps makes calendar 0 active for the next pass.
- R8: With sw_en high, sel_valid requests calendar sel_cal; the request is registered and applied at the first wrap step in a later cycle, never mid-pass. out_cal gives the calendar each emitted entry came from.
- R9: When several requests arrive before a wrap, the most recent one decides the calendar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for a calendar entry |
| cfg_rd | input | 1 | Host read strobe for a calendar entry |
| cfg_cal | input | 1 | Calendar addressed by the host (0 or 1) |
| cfg_addr | input | 8 | Entry addressed by the host |
| cfg_wdata | input | 8 | Port number to store |
| cfg_rdata | output | 8 | Entry read back, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| len_we | input | 1 | Pass length write strobe |
| len_val | input | 9 | New pass length (1 to 256 accepted) |
| sw_en | input | 1 | Calendar switching enable |
| sel_valid | input | 1 | Calendar-selection word received |
| sel_cal | input | 1 | Calendar requested by the selection word |
| step_en | input | 1 | Request the next status slot |
| out_valid | output | 1 | A port number is emitted this cycle |
| out_port | output | 8 | Emitted logical-port number |
| out_first | output | 1 | Emission is entry 0 of a pass |
| out_cal | output | 1 | Calendar that supplied the emission |

## Verification
The assertions take for granted that rst_n is held low for at least one clock before any check matters and that sel_valid, step_en and the host strobes are free of X after reset; they make no assumption on the order or density of steps, requests or length writes. The stimulus keeps every input at a defined 0 or 1 from time zero, holds reset for several cycles, and then mixes directed passes (short lengths, length 1, length shrinks, requests at and away from a wrap, back-to-back requests, enable dropped while calendar 1 is active) with a long run of random strobes, lengths including illegal ones, and host traffic that collides with the walk.

// File: rtl/sched_pkg.sv
// Shared definitions for the status calendar scheduler.
// Assumes exactly two calendars, named A (index 0) and B (index 1).
package sched_pkg;
    localparam int unsigned NUM_CAL = 2;

    typedef enum logic {
        CAL_A = 1'b0,
        CAL_B = 1'b1
    } cal_id_t;
endpackage

// File: rtl/cal_store.sv
// Holds both calendars as register banks. The host port writes one entry
// per cycle and returns a registered read one cycle after the strobe.
// The walker reads combinationally from the bank chosen by sched_cal.
// Assumes host_addr and sched_idx are always below DEPTH.
module cal_store
    import sched_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic              host_cal,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [PORT_W-1:0] host_wdata,
    output logic [PORT_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              sched_cal,
    input  logic [IDX_W-1:0]  sched_idx,
    output logic [PORT_W-1:0] sched_data
);

    logic [PORT_W-1:0] host_view  [NUM_CAL];
    logic [PORT_W-1:0] sched_view [NUM_CAL];

    for (genvar g = 0; g < NUM_CAL; g++) begin : g_bank
        logic [PORT_W-1:0] bank_q [DEPTH];
        logic              bank_hit;

        assign bank_hit = host_we && (host_cal == g[0]);

        // Clear the bank on reset, otherwise store the addressed host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    bank_q[i] <= '0;
                end
            end else if (bank_hit) begin
                bank_q[host_addr] <= host_wdata;
            end
        end

        assign host_view[g]  = bank_q[host_addr];
        assign sched_view[g] = bank_q[sched_idx];
    end

    assign sched_data = sched_view[sched_cal];

    // Register the host read; data holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_re;
            if (host_re) begin
                host_rdata <= host_view[host_cal];
            end
        end
    end

    // R2
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_re |=> host_rvalid);

    // R2
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> !host_rvalid);

    // R2
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> $stable(host_rdata));

endmodule

// File: rtl/cal_walker.sv
// Walks the entry index through one pass of the active calendar and keeps
// the pass length register. A step at entry length-1, or beyond it after
// the length was lowered, wraps the index to 0.
// Assumes len_in is only trusted when it lies in 1..DEPTH.
module cal_walker #(
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned LEN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_in,
    output logic [IDX_W-1:0] idx_q,
    output logic             at_first,
    output logic             wrap
);

    logic [LEN_W-1:0] len_q;
    logic             len_ok;
    logic             at_end;

    assign len_ok   = (len_in != '0) && (len_in <= LEN_W'(DEPTH));
    assign at_end   = (LEN_W'(idx_q) + LEN_W'(1)) >= len_q;
    assign wrap     = step && at_end;
    assign at_first = (idx_q == '0);

    // Accept only legal pass lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LEN_W'(DEPTH);
        end else if (len_we && len_ok) begin
            len_q <= len_in;
        end
    end

    // Advance the index per step, returning to 0 at the end of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wrap) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // R5
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) && (len_q <= LEN_W'(DEPTH)));

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (idx_q == '0));

    // R3
    advance_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap) |=> (idx_q == $past(idx_q) + 1'b1));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(idx_q));

endmodule

// File: rtl/cal_switch.sv
// Chooses the active calendar. A selection word seen while switching is
// enabled is parked as a pending request; the request is applied at a
// later wrap. With switching disabled every wrap returns to calendar A.
// Assumes wrap is a single-cycle strobe from the walker.
module cal_switch
    import sched_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sw_en,
    input  logic    sel_valid,
    input  logic    sel_cal,
    input  logic    wrap,
    output cal_id_t active
);

    logic    pend_q;
    cal_id_t pend_cal;
    cal_id_t next_active;

    // Pick the calendar for the pass that starts after a wrap.
    always_comb begin
        if (!sw_en) begin
            next_active = CAL_A;
        end else if (pend_q) begin
            next_active = pend_cal;
        end else begin
            next_active = active;
        end
    end

    // Apply at wrap; a new request in the same cycle is kept for later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= CAL_A;
            pend_q   <= 1'b0;
            pend_cal <= CAL_A;
        end else begin
            if (wrap) begin
                active <= next_active;
                pend_q <= 1'b0;
            end
            if (sel_valid && sw_en) begin
                pend_q   <= 1'b1;
                pend_cal <= cal_id_t'(sel_cal);
            end
        end
    end

    // R8
    change_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(wrap));

    // R7
    disabled_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !sw_en) |=> (active == CAL_A));

    // R7
    disabled_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && !pend_q && !wrap) |=> !pend_q);

endmodule

// File: rtl/status_cal_sched.sv
// Top of the status calendar scheduler. Joins the calendar store, the
// index walker and the calendar switch, and registers each emitted slot.
// Assumes step_en is asserted by a formatter that consumes one slot per
// cycle in which it is high.
module status_cal_sched
    import sched_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned LEN_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_rd,
    input  logic              cfg_cal,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [PORT_W-1:0] cfg_wdata,
    output logic [PORT_W-1:0] cfg_rdata,
    output logic              cfg_rvalid,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              sw_en,
    input  logic              sel_valid,
    input  logic              sel_cal,
    input  logic              step_en,
    output logic              out_valid,
    output logic [PORT_W-1:0] out_port,
    output logic              out_first,
    output logic              out_cal
);

    logic [IDX_W-1:0]  idx;
    logic              idx_first;
    logic              pass_wrap;
    cal_id_t           active;
    logic [PORT_W-1:0] slot_data;

    cal_store #(
        .PORT_W (PORT_W),
        .DEPTH  (DEPTH)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (cfg_we),
        .host_re     (cfg_rd),
        .host_cal    (cfg_cal),
        .host_addr   (cfg_addr),
        .host_wdata  (cfg_wdata),
        .host_rdata  (cfg_rdata),
        .host_rvalid (cfg_rvalid),
        .sched_cal   (active),
        .sched_idx   (idx),
        .sched_data  (slot_data)
    );

    cal_walker #(
        .DEPTH (DEPTH)
    ) i_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_en),
        .len_we   (len_we),
        .len_in   (len_val),
        .idx_q    (idx),
        .at_first (idx_first),
        .wrap     (pass_wrap)
    );

    cal_switch i_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_en     (sw_en),
        .sel_valid (sel_valid),
        .sel_cal   (sel_cal),
        .wrap      (pass_wrap),
        .active    (active)
    );

    // Register the slot taken in a step cycle; port and calendar hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_port  <= '0;
            out_cal   <= 1'b0;
        end else begin
            out_valid <= step_en;
            out_first <= step_en && idx_first;
            if (step_en) begin
                out_port <= slot_data;
                out_cal  <= active;
            end
        end
    end

    // R3
    valid_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> out_valid);

    // R3
    quiet_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !out_valid);

    // R4
    first_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    // R8
    cal_fixed_mid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first) |-> $stable(out_cal));

endmodule

// File: tb/test_status_cal_sched.sv
module test_status_cal_sched;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_rd = 1'b0, cfg_cal = 1'b0;
    logic [7:0] cfg_addr = '0, cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cfg_rvalid;
    logic       len_we = 1'b0;
    logic [8:0] len_val = '0;
    logic       sw_en = 1'b0, sel_valid = 1'b0, sel_cal = 1'b0, step_en = 1'b0;
    logic       out_valid, out_first, out_cal;
    logic [7:0] out_port;

    status_cal_sched i_status_cal_sched (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_cal(cfg_cal),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .len_we(len_we), .len_val(len_val),
        .sw_en(sw_en), .sel_valid(sel_valid), .sel_cal(sel_cal),
        .step_en(step_en),
        .out_valid(out_valid), .out_port(out_port),
        .out_first(out_first), .out_cal(out_cal)
    );

    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string phase = "R1 reset";

    // reference model state
    int m_mem [2][DEPTH];
    int m_idx, m_len, m_act, m_pend, m_pcal;
    int e_valid, e_port, e_first, e_cal, e_rvalid, e_rdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < DEPTH; i++) m_mem[c][i] = 0;
        m_idx = 0; m_len = DEPTH; m_act = 0; m_pend = 0; m_pcal = 0;
    endtask

    // One clock of the reference model, using the inputs now applied.
    task automatic model_step();
        e_rvalid = cfg_rd;
        if (cfg_rd) e_rdata = m_mem[cfg_cal][cfg_addr];
        e_valid = step_en;
        e_first = step_en && (m_idx == 0);
        if (step_en) begin
            e_port = m_mem[m_act][m_idx];
            e_cal  = m_act;
            if (m_idx + 1 >= m_len) begin
                m_idx = 0;
                if (!sw_en) m_act = 0;
                else if (m_pend != 0) m_act = m_pcal;
                m_pend = 0;
            end else begin
                m_idx++;
            end
        end
        if (sel_valid && sw_en) begin
            m_pend = 1; m_pcal = sel_cal;
        end
        if (len_we && len_val >= 1 && len_val <= DEPTH) m_len = len_val;
        if (cfg_we) m_mem[cfg_cal][cfg_addr] = cfg_wdata;
    endtask

    task automatic compare();
        check(out_valid === e_valid[0], "R3", out_valid, e_valid);
        check(out_first === e_first[0], "R4", out_first, e_first);
        if (e_valid != 0) begin
            check(out_port === e_port[7:0], "R3", out_port, e_port);
            check(out_cal === e_cal[0], "R8", out_cal, e_cal);
        end
        check(cfg_rvalid === e_rvalid[0], "R2", cfg_rvalid, e_rvalid);
        if (e_rvalid != 0) check(cfg_rdata === e_rdata[7:0], "R2", cfg_rdata, e_rdata);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        cfg_we = 0; cfg_rd = 0; len_we = 0; sel_valid = 0; step_en = 0;
    endtask

    task automatic wr(input int c, input int a, input int d);
        cfg_we = 1; cfg_cal = c[0]; cfg_addr = a[7:0]; cfg_wdata = d[7:0]; tick();
    endtask

    task automatic rd(input int c, input int a);
        cfg_rd = 1; cfg_cal = c[0]; cfg_addr = a[7:0]; tick();
    endtask

    task automatic set_len(input int v);
        len_we = 1; len_val = v[8:0]; tick();
    endtask

    task automatic req(input int c);
        sel_valid = 1; sel_cal = c[0]; tick();
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) begin
            step_en = 1; tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(out_valid === 1'b0, "R1", out_valid, 0);
        check(cfg_rvalid === 1'b0, "R1", cfg_rvalid, 0);
        check(out_cal === 1'b0, "R1", out_cal, 0);
        rst_n = 1;
        e_valid = 0; e_first = 0; e_rvalid = 0;

        // R1: first step is entry 0 of calendar 0, cleared memory
        steps(1);
        rd(1, 200);
        steps(2);

        phase = "R2 host access";
        for (int i = 0; i < DEPTH; i++) wr(0, i, (i * 7 + 3) & 255);
        for (int i = 0; i < DEPTH; i++) wr(1, i, 255 - i);
        rd(0, 0); rd(0, 255); rd(1, 17); rd(1, 255);
        cfg_rd = 1; wr(0, 5, 99);   // read and write same entry, same cycle
        rd(0, 5);

        phase = "R3 repeated ports";
        wr(0, 0, 9); wr(0, 2, 9); wr(0, 4, 9);
        set_len(1);   // force a wrap to restart at 0 on the next step
        steps(1);
        set_len(DEPTH);
        for (int k = 0; k < 6; k++) begin step_en = k[0]; tick(); end
        steps(6);

        phase = "R5 length";
        set_len(5);
        steps(12);
        set_len(0); steps(6);
        set_len(300); steps(6);
        set_len(1); steps(3);
        set_len(4); steps(5);

        phase = "R6 shrink";
        set_len(8); steps(8); steps(6);
        set_len(3); steps(4);

        phase = "R7 disabled";
        set_len(4);
        sw_en = 0;
        req(1); steps(9);
        check(out_cal === 1'b0, "R7", out_cal, 0);

        phase = "R8 switch";
        sw_en = 1;
        steps(1);
        req(1); steps(10);
        check(out_cal === 1'b1, "R8", out_cal, 1);
        steps(3);
        sel_valid = 1; sel_cal = 0; step_en = 1; tick();  // request in the wrap cycle
        steps(8);

        phase = "R9 last request";
        req(1); req(0); req(1); steps(9);
        req(0); req(1); req(0); steps(9);

        phase = "R7 enable dropped";
        req(1); steps(8);
        sw_en = 0; steps(8);
        check(out_cal === 1'b0, "R7", out_cal, 0);

        phase = "R3 R8 random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            step_en = ($urandom_range(0, 3) != 0);
            sw_en = (r > 10);
            if ($urandom_range(0, 9) == 0) begin sel_valid = 1; sel_cal = $urandom_range(0, 1); end
            if ($urandom_range(0, 49) == 0) begin len_we = 1; len_val = 9'($urandom_range(0, 300)); end
            if ($urandom_range(0, 4) == 0) begin
                cfg_we = 1; cfg_cal = $urandom_range(0, 1);
                cfg_addr = 8'($urandom_range(0, 15)); cfg_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 4) == 0) begin
                cfg_rd = 1; cfg_cal = $urandom_range(0, 1); cfg_addr = 8'($urandom_range(0, 15));
            end
            if (n == 100) begin len_we = 1; len_val = 9'd7; end
            tick();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule